// File: doc/BRIEF.md
# Frame Buffer Slot Arbiter

This block decides which frame-sized slot of external memory each side of a frame buffer works on. A write side fills one slot with incoming video and a read side drains another. When a side finishes a frame it sends a one-cycle completion strobe. The arbiter answers with the slot index that side must use next, a stall flag, and one-cycle pulses that mark a dropped input frame or a repeated output frame. Address generation, memory traffic and pixel datapaths belong to the surrounding logic.

The parameter `TRIPLE` selects the variant. With two slots, the sides swap only after both have finished. With three slots, a spare slot carries a fresh/stale mark. In the free-running mode this mark alone decides whether a finishing side swaps, drops, repeats or waits. A run-time locked mode replaces that decision with a signed accumulator driven by two programmed step values, so drops and repeats follow a fixed rate ratio. The slot moves still obey the fresh/stale mark.

The completion strobes are plain control inputs with no handshake. The only back-pressure is the stall output: while a side's stall is high, the completion strobes from that side are ignored. That side must not begin a new frame until its stall falls and its slot output shows the slot to use.

Top module: `fb_slot_arbiter`

## Requirements
- R1: After reset, with three slots, the write slot is 0, the read slot is 1, the spare is slot 2 and is stale, the write stall is 0, the read stall is 1, and both pulses are 0.
- R2: With three slots, a write completion while the spare is stale swaps the write slot with the spare and marks the spare fresh. The new write slot appears on the cycle after the strobe.
- R3: A write completion while the spare is fresh and dropping is allowed keeps the write slot and raises drop_pulse for exactly one cycle, on the cycle after the strobe.
- R4: A write completion while the spare is fresh and dropping is not allowed raises the write stall. The stall holds until the read side leaves a stale spare. The writer then swaps one cycle later. Write strobes during the stall have no effect.
- R5: A read completion while the spare is fresh swaps the read slot with the spare and marks the spare stale. A read side that is waiting takes a fresh spare in the same cycle the writer produces it.
- R6: A read completion while the spare is stale and repeating is allowed keeps the read slot and raises repeat_pulse for one cycle. A read side that has never received a frame ignores read strobes and never repeats.
- R7: A read completion while the spare is stale and repeating is not allowed raises the read stall until a fresh spare appears.
- R8: When both strobes arrive in the same cycle, the write side's update is applied first, and the read side then decides on the spare as updated by the write side.
- R9: No slot is ever held by two roles. All slot indices stay below the slot count.
- R10: With two slots (TRIPLE=0), write slot and read slot always differ. They exchange only once both sides have completed, and each side stalls while it waits for the other. There are never drop or repeat pulses.
- R11: With lock_en high, the drop and repeat decisions come from the accumulator and not from the spare mark. A write completion drops if the accumulator is above zero; otherwise it adds lock_in_step. A read completion, judged after the same-cycle write update, repeats if the accumulator is at or below zero; otherwise it subtracts lock_out_step. A kept frame still swaps, or stalls, according to the spare mark.
- R12: While lock_en is low, the accumulator is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_frame_done | input | 1 | One-cycle strobe: write side finished a frame |
| rd_frame_done | input | 1 | One-cycle strobe: read side finished a frame |
| drop_allow | input | 1 | Free-running mode: writer may drop when the spare is fresh |
| repeat_allow | input | 1 | Free-running mode: reader may repeat when the spare is stale |
| lock_en | input | 1 | Selects the locked-rate decision (three slots only) |
| lock_in_step | input | RATE_W | Amount added to the accumulator per kept input frame |
| lock_out_step | input | RATE_W | Amount subtracted from the accumulator per advanced output frame |
| wr_slot | output | 2 | Slot the write side fills |
| rd_slot | output | 2 | Slot the read side drains |
| wr_stall | output | 1 | Write side must wait |
| rd_stall | output | 1 | Read side must wait |
| drop_pulse | output | 1 | One-cycle flag: the frame just written was discarded |
| repeat_pulse | output | 1 | One-cycle flag: the read slot is sent again |

## Verification
The assertions assume that the completion strobes mean what they say: a side only strobes while it is working on the slot it was last given. They also assume that reset is applied before any strobe is honoured. Under those assumptions, slot exclusivity and the stability of a stalled or dropping side's slot follow from the inputs alone. The stimulus keeps to single-cycle strobes driven between clock edges. It changes lock_en and the step values only while no strobe is active, so every expected slot index follows from counting swaps by hand.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int SLOT_W = 2;
  typedef logic [SLOT_W-1:0] slot_t;
  localparam slot_t SLOT_A = 2'd0;
  localparam slot_t SLOT_B = 2'd1;
  localparam slot_t SLOT_C = 2'd2;
endpackage

// File: rtl/fbs_lock_acc.sv
module fbs_lock_acc #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic [RATE_W-1:0] in_step,
  input  logic [RATE_W-1:0] out_step,
  input  logic              w_evt,
  input  logic              r_evt,
  output logic              w_drop,
  output logic              r_rep
);
  localparam int ACC_W = RATE_W + 2;
  localparam logic signed [ACC_W-1:0] ACC_MAX = (1 <<< RATE_W) - 1;

  logic signed [ACC_W-1:0] acc_q, acc_w, acc_r;
  logic signed [ACC_W-1:0] in_ext, out_ext;

  assign in_ext  = $signed({2'b00, in_step});
  assign out_ext = $signed({2'b00, out_step});

  always_comb begin
    // write side decides first
    w_drop = (acc_q > 0);
    acc_w  = (w_evt && !w_drop) ? acc_q + in_ext : acc_q;
    // read side sees the write-updated accumulator
    r_rep  = (acc_w <= 0);
    acc_r  = (r_evt && !r_rep) ? acc_w - out_ext : acc_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (!lock_en) acc_q <= '0;
    else               acc_q <= acc_r;
  end

  // accumulator only grows from <=0 and shrinks from >0, so it stays bounded
  assert_acc_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= ACC_MAX) && (acc_q >= -ACC_MAX));

  assert_acc_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> (acc_q == 0));
endmodule

// File: rtl/fbs_triple_core.sv
module fbs_triple_core
  import fbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_done,
  input  logic  rd_done,
  input  logic  drop_allow,
  input  logic  repeat_allow,
  input  logic  lock_en,
  input  logic  lk_drop,
  input  logic  lk_rep,
  output logic  w_evt,
  output logic  r_evt,
  output slot_t wr_slot,
  output slot_t rd_slot,
  output logic  wr_stall,
  output logic  rd_stall,
  output logic  drop_pulse,
  output logic  repeat_pulse
);
  slot_t w_q, r_q, s_q;
  logic  fresh_q, wpend_q, rpend_q, drop_q, rep_q;

  slot_t w_n, r_n, s_mid, s_n;
  logic  fresh_mid, fresh_n, wpend_n, rpend_n, drop_n, rep_n;
  logic  w_drop_dec, r_rep_dec;

  assign w_evt = wr_done && !wpend_q;
  assign r_evt = rd_done && !rpend_q;

  always_comb begin
    // ---- write stage ----
    w_n       = w_q;
    s_mid     = s_q;
    fresh_mid = fresh_q;
    wpend_n   = wpend_q;
    drop_n    = 1'b0;
    w_drop_dec = lock_en ? lk_drop : (fresh_q && drop_allow);
    if (w_evt && w_drop_dec) begin
      drop_n = 1'b1;
    end else if (w_evt || wpend_q) begin
      if (!fresh_q) begin
        w_n       = s_q;
        s_mid     = w_q;
        fresh_mid = 1'b1;
        wpend_n   = 1'b0;
      end else begin
        wpend_n = 1'b1;
      end
    end
    // ---- read stage, on the write-updated spare ----
    r_n     = r_q;
    s_n     = s_mid;
    fresh_n = fresh_mid;
    rpend_n = rpend_q;
    rep_n   = 1'b0;
    r_rep_dec = lock_en ? lk_rep : (!fresh_mid && repeat_allow);
    if (r_evt && r_rep_dec) begin
      rep_n = 1'b1;
    end else if (r_evt || rpend_q) begin
      if (fresh_mid) begin
        r_n     = s_mid;
        s_n     = r_q;
        fresh_n = 1'b0;
        rpend_n = 1'b0;
      end else begin
        rpend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q     <= SLOT_A;
      r_q     <= SLOT_B;
      s_q     <= SLOT_C;
      fresh_q <= 1'b0;
      wpend_q <= 1'b0;
      rpend_q <= 1'b1;
      drop_q  <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      w_q     <= w_n;
      r_q     <= r_n;
      s_q     <= s_n;
      fresh_q <= fresh_n;
      wpend_q <= wpend_n;
      rpend_q <= rpend_n;
      drop_q  <= drop_n;
      rep_q   <= rep_n;
    end
  end

  assign wr_slot      = w_q;
  assign rd_slot      = r_q;
  assign wr_stall     = wpend_q;
  assign rd_stall     = rpend_q;
  assign drop_pulse   = drop_q;
  assign repeat_pulse = rep_q;

  assert_slots_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q != r_q) && (w_q != s_q) && (r_q != s_q) &&
    (w_q < 3) && (r_q < 3) && (s_q < 3));

  assert_drop_keeps_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> $stable(w_q));

  assert_repeat_keeps_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> $stable(r_q));

  assert_wstall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wpend_q |=> (!wpend_q || $stable(w_q)));

  assert_rstall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rpend_q |=> (!rpend_q || $stable(r_q)));

  assert_no_drop_while_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wpend_q |=> !drop_q);
endmodule

// File: rtl/fbs_double_core.sv
module fbs_double_core
  import fbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_done,
  input  logic  rd_done,
  output slot_t wr_slot,
  output slot_t rd_slot,
  output logic  wr_stall,
  output logic  rd_stall
);
  logic sel_q, wpend_q, rpend_q;
  logic w_arr, r_arr;

  assign w_arr = wr_done || wpend_q;
  assign r_arr = rd_done || rpend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wpend_q <= 1'b0;
      rpend_q <= 1'b1;
    end else if (w_arr && r_arr) begin
      sel_q   <= !sel_q;
      wpend_q <= 1'b0;
      rpend_q <= 1'b0;
    end else begin
      wpend_q <= w_arr;
      rpend_q <= r_arr;
    end
  end

  assign wr_slot  = sel_q ? SLOT_B : SLOT_A;
  assign rd_slot  = sel_q ? SLOT_A : SLOT_B;
  assign wr_stall = wpend_q;
  assign rd_stall = rpend_q;

  assert_double_distinct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot != rd_slot) && (wr_slot < 2) && (rd_slot < 2));

  assert_double_no_lone_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_arr || !r_arr) |=> $stable(wr_slot));
endmodule

// File: rtl/fb_slot_arbiter.sv
module fb_slot_arbiter
  import fbs_pkg::*;
#(
  parameter bit TRIPLE = 1'b1,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_frame_done,
  input  logic              rd_frame_done,
  input  logic              drop_allow,
  input  logic              repeat_allow,
  input  logic              lock_en,
  input  logic [RATE_W-1:0] lock_in_step,
  input  logic [RATE_W-1:0] lock_out_step,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              wr_stall,
  output logic              rd_stall,
  output logic              drop_pulse,
  output logic              repeat_pulse
);
  generate
    if (TRIPLE) begin : g_triple
      logic w_evt, r_evt, lk_drop, lk_rep;

      fbs_lock_acc #(.RATE_W(RATE_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_en  (lock_en),
        .in_step  (lock_in_step),
        .out_step (lock_out_step),
        .w_evt    (w_evt),
        .r_evt    (r_evt),
        .w_drop   (lk_drop),
        .r_rep    (lk_rep)
      );

      fbs_triple_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_done      (wr_frame_done),
        .rd_done      (rd_frame_done),
        .drop_allow   (drop_allow),
        .repeat_allow (repeat_allow),
        .lock_en      (lock_en),
        .lk_drop      (lk_drop),
        .lk_rep       (lk_rep),
        .w_evt        (w_evt),
        .r_evt        (r_evt),
        .wr_slot      (wr_slot),
        .rd_slot      (rd_slot),
        .wr_stall     (wr_stall),
        .rd_stall     (rd_stall),
        .drop_pulse   (drop_pulse),
        .repeat_pulse (repeat_pulse)
      );
    end else begin : g_double
      fbs_double_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_done  (wr_frame_done),
        .rd_done  (rd_frame_done),
        .wr_slot  (wr_slot),
        .rd_slot  (rd_slot),
        .wr_stall (wr_stall),
        .rd_stall (rd_stall)
      );
      assign drop_pulse   = 1'b0;
      assign repeat_pulse = 1'b0;
    end
  endgenerate
endmodule

// File: tb/fb_slot_arbiter_tb.sv
module fb_slot_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic wd = 0, rd = 0, dw = 0, dr = 0;
  logic drop_allow = 0, repeat_allow = 0, lock_en = 0;
  logic [7:0] in_step = 8'd1, out_step = 8'd1;

  logic [1:0] wslot, rslot, dwslot, drslot;
  logic wst, rst, dpl, rpl, dwst, drst, ddpl, drpl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fb_slot_arbiter #(.TRIPLE(1'b1), .RATE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_frame_done(wd), .rd_frame_done(rd),
    .drop_allow(drop_allow), .repeat_allow(repeat_allow), .lock_en(lock_en),
    .lock_in_step(in_step), .lock_out_step(out_step),
    .wr_slot(wslot), .rd_slot(rslot), .wr_stall(wst), .rd_stall(rst),
    .drop_pulse(dpl), .repeat_pulse(rpl));

  fb_slot_arbiter #(.TRIPLE(1'b0), .RATE_W(8)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .wr_frame_done(dw), .rd_frame_done(dr),
    .drop_allow(1'b1), .repeat_allow(1'b1), .lock_en(1'b0),
    .lock_in_step(8'd1), .lock_out_step(8'd1),
    .wr_slot(dwslot), .rd_slot(drslot), .wr_stall(dwst), .rd_stall(drst),
    .drop_pulse(ddpl), .repeat_pulse(drpl));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // triple instance full state check
  task automatic st(input string tag, input int ew, input int er, input int ews,
                    input int ers, input int ed, input int ep);
    chk({tag, " wr_slot"}, wslot, ew);
    chk({tag, " rd_slot"}, rslot, er);
    chk({tag, " wr_stall"}, wst, ews);
    chk({tag, " rd_stall"}, rst, ers);
    chk({tag, " drop"}, dpl, ed);
    chk({tag, " repeat"}, rpl, ep);
    chk({tag, " R9 distinct"}, int'(wslot != rslot && wslot < 3 && rslot < 3), 1);
  endtask

  task automatic dst(input string tag, input int ew, input int er, input int ews, input int ers);
    chk({tag, " wr_slot"}, dwslot, ew);
    chk({tag, " rd_slot"}, drslot, er);
    chk({tag, " wr_stall"}, dwst, ews);
    chk({tag, " rd_stall"}, drst, ers);
    chk({tag, " no pulses"}, int'(ddpl | drpl), 0);
  endtask

  // strobe for one cycle from a negedge; returns at the following negedge
  task automatic pulse(input logic w, input logic r);
    wd = w; rd = r;
    @(negedge clk);
    wd = 0; rd = 0;
  endtask

  task automatic dpulse(input logic w, input logic r);
    dw = w; dr = r;
    @(negedge clk);
    dw = 0; dr = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    st("R1 reset", 0, 1, 0, 1, 0, 0);

    drop_allow = 1; repeat_allow = 1;
    pulse(0, 1);
    st("R6 unprimed reader ignores strobe", 0, 1, 0, 1, 0, 0);
    pulse(1, 0);
    st("R2/R5 first frame", 2, 0, 0, 0, 0, 0);
    pulse(1, 0);
    st("R2 swap with stale spare", 1, 0, 0, 0, 0, 0);
    pulse(1, 0);
    st("R3 drop on fresh spare", 1, 0, 0, 0, 1, 0);
    @(negedge clk);
    st("R3 drop pulse one cycle", 1, 0, 0, 0, 0, 0);
    pulse(0, 1);
    st("R5 reader takes fresh spare", 1, 2, 0, 0, 0, 0);
    pulse(0, 1);
    st("R6 repeat on stale spare", 1, 2, 0, 0, 0, 1);

    drop_allow = 0; repeat_allow = 0;
    pulse(1, 0);
    st("R2 swap", 0, 2, 0, 0, 0, 0);
    pulse(1, 0);
    st("R4 writer stalls", 0, 2, 1, 0, 0, 0);
    pulse(1, 0);
    st("R4 strobe while stalled ignored", 0, 2, 1, 0, 0, 0);
    pulse(0, 1);
    st("R4 stall held during reader swap", 0, 1, 1, 0, 0, 0);
    @(negedge clk);
    st("R4 writer released next cycle", 2, 1, 0, 0, 0, 0);
    pulse(0, 1);
    st("R5 reader swap", 2, 0, 0, 0, 0, 0);
    pulse(0, 1);
    st("R7 reader stalls", 2, 0, 0, 1, 0, 0);
    pulse(1, 0);
    st("R7/R5 reader released same cycle", 1, 2, 0, 0, 0, 0);
    pulse(1, 1);
    st("R8 write-first ordering a", 0, 1, 0, 0, 0, 0);
    pulse(1, 1);
    st("R8 write-first ordering b", 2, 0, 0, 0, 0, 0);

    // locked mode, steps 1/1
    lock_en = 1; in_step = 8'd1; out_step = 8'd1;
    pulse(1, 0);
    st("R11 kept frame swaps", 1, 0, 0, 0, 0, 0);
    pulse(1, 0);
    st("R11 accumulator drop overrides spare", 1, 0, 0, 0, 1, 0);
    pulse(0, 1);
    st("R11 reader advances", 1, 2, 0, 0, 0, 0);
    pulse(0, 1);
    st("R11 accumulator repeat overrides spare", 1, 2, 0, 0, 0, 1);

    // locked mode, input step 2
    in_step = 8'd2;
    pulse(1, 0);
    st("R11 step2 keep", 0, 2, 0, 0, 0, 0);
    pulse(0, 1);
    st("R11 step2 advance 1", 0, 1, 0, 0, 0, 0);
    pulse(0, 1);
    st("R11 step2 advance 2 stalls on stale spare", 0, 1, 0, 1, 0, 0);
    pulse(1, 0);
    st("R11 step2 keep releases reader", 2, 0, 0, 0, 0, 0);

    // R12: dropping lock_en clears the accumulator (it was 2)
    lock_en = 0;
    @(negedge clk);
    lock_en = 1; in_step = 8'd1;
    @(negedge clk);
    pulse(0, 1);
    st("R12 cleared accumulator repeats", 2, 0, 0, 0, 0, 1);
    lock_en = 0;

    // two-slot variant
    dst("R10 reset", 0, 1, 0, 1);
    dpulse(1, 0);
    dst("R10 first exchange", 1, 0, 0, 0);
    dpulse(1, 0);
    dst("R10 writer waits", 1, 0, 1, 0);
    dpulse(1, 0);
    dst("R10 strobe while waiting ignored", 1, 0, 1, 0);
    dpulse(0, 1);
    dst("R10 both done exchange", 0, 1, 0, 0);
    dpulse(0, 1);
    dst("R10 reader waits", 0, 1, 0, 1);
    dpulse(1, 0);
    dst("R10 exchange on writer", 1, 0, 0, 0);
    dpulse(1, 1);
    dst("R10 simultaneous exchange", 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    dst("R10 idle keeps state", 0, 1, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule